// File: doc/BRIEF.md
# Secured Configuration Store

This block is the non-volatile configuration keeper of a small programmable logic device. It holds the AND-array connection words, a word of macrocell architecture bits and a signature word. It also holds a security flag. A programmer drives it through a parallel command port. Each accepted command runs for a fixed number of cycles. Completion is marked by a one-cycle done pulse that carries either read data or an error flag.

Connections obey erased-cell semantics. A bulk erase opens every connection, which stores zeros. Programming only closes connections, so written data is ORed into the stored word. Once the security flag is set, the array, the architecture word and the signature can no longer be read or programmed. A bulk erase is the only way out, and it wipes the whole pattern along with the lock. The flag can be set right after programming or at any later time.

Top module: `cfg_store_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `rdata_o` are 0. All storage reads as zero and the lock is clear.
- R2: A command is accepted when `cmd_valid_i` is high and `busy_o` is low at a clock edge. The command codes are 0 none, 1 erase, 2 program word, 3 read word, 4 program signature, 5 read signature and 6 secure; code 7 is undefined. `busy_o` is high from the next cycle. `done_o` is high for exactly one cycle, `LATENCY` cycles after the accepting edge. `busy_o` is low in that same cycle.
- R3: `cmd_valid_i` has no effect while `busy_o` is high.
- R4: Program word ORs `wdata_i` into the addressed word. No stored bit returns to 0 except through erase.
- R5: A permitted read returns the stored word on `rdata_o` in the done cycle, with `err_o` low. `rdata_o` is zero in every other cycle.
- R6: Erase is always permitted. It clears every array word, the architecture word, both signature halves and the lock.
- R7: The signature is `SIG_W` bits held as `DATA_W`-bit halves. `addr_i` value 0 selects the low half and value 1 the high half. Program signature ORs into the selected half, and read signature returns it.
- R8: Secure sets the lock. It is permitted in any state and completes without error, including when the lock is already set.
- R9: While the lock is set, program word, read word, program signature and read signature are refused. A refused command pulses `err_o` in its done cycle, returns zero data and leaves storage unchanged.
- R10: Word commands with `addr_i` above `NUM_WORDS` are refused with `err_o`. Array words are 0..NUM_WORDS-1 and the architecture word is at `NUM_WORDS`. Signature commands with `addr_i` of 2 or more are also refused.
- R11: Code 0 and code 7 complete with no error, zero data and no change to storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 3 | Command code |
| addr_i | input | ADDR_W | Word or signature-half index |
| wdata_i | input | DATA_W | Program data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command completion pulse |
| err_o | output | 1 | Command refused, valid with `done_o` |
| rdata_o | output | DATA_W | Read data, valid with `done_o` |

## Verification
The assertions assume that `cmd_i`, `addr_i` and `wdata_i` come from a synchronous source and are known whenever `cmd_valid_i` is high. They make no assumption about how often requests arrive, because requests during `busy_o` must be dropped. The stimulus changes inputs only on the falling edge and issues requests while the block is busy on purpose. Random addresses cover the whole `ADDR_W` range, so refused indices are reached regularly. Erase and secure are weighted low so that long programmed and locked stretches occur.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_ERASE    = 3'd1,
    CMD_PROG     = 3'd2,
    CMD_READ     = 3'd3,
    CMD_PROG_SIG = 3'd4,
    CMD_READ_SIG = 3'd5,
    CMD_SECURE   = 3'd6
  } cmd_e;
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic fire_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign accept_o = req_i && !busy_q;
  assign fire_o   = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(LATENCY - 1);
      end else if (fire_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire_o) |=> busy_o);
  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
endmodule

// File: rtl/cfg_mem.sv
module cfg_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 65,
  parameter int AW     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                word_q[g] <= '0;
      else if (erase_i)                           word_q[g] <= '0;
      else if (wr_i && (addr_i == AW'(g)))        word_q[g] <= word_q[g] | wdata_i;
    end

    assert_bits_stay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !erase_i |=> ((word_q[g] & $past(word_q[g])) == $past(word_q[g])));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (addr_i == AW'(i)) rdata_o = word_q[i];
  end
endmodule

// File: rtl/cfg_lock.sv
module cfg_lock
  import cfg_store_pkg::*;
#(
  parameter int NUM_WORDS = 64,
  parameter int SIG_WORDS = 2,
  parameter int ADDR_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              erase_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              sig_wr_o,
  output logic              sig_rd_o,
  output logic              refuse_o
);
  logic secure_q;
  logic word_cmd, sig_cmd, in_arr, in_sig, bad;

  assign word_cmd = (cmd_i == CMD_PROG) || (cmd_i == CMD_READ);
  assign sig_cmd  = (cmd_i == CMD_PROG_SIG) || (cmd_i == CMD_READ_SIG);
  assign in_arr   = addr_i <= ADDR_W'(NUM_WORDS);
  assign in_sig   = addr_i <  ADDR_W'(SIG_WORDS);
  assign bad      = secure_q || (word_cmd && !in_arr) || (sig_cmd && !in_sig);

  assign erase_o  = fire_i && (cmd_i == CMD_ERASE);
  assign wr_o     = fire_i && !bad && (cmd_i == CMD_PROG);
  assign rd_o     = fire_i && !bad && (cmd_i == CMD_READ);
  assign sig_wr_o = fire_i && !bad && (cmd_i == CMD_PROG_SIG);
  assign sig_rd_o = fire_i && !bad && (cmd_i == CMD_READ_SIG);
  assign refuse_o = fire_i && bad && (word_cmd || sig_cmd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              secure_q <= 1'b0;
    else if (erase_o)                         secure_q <= 1'b0;
    else if (fire_i && cmd_i == CMD_SECURE)   secure_q <= 1'b1;
  end

  assert_erase_unlocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |=> !secure_q);
  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure_q && !erase_o) |=> secure_q);
  assert_secure_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && secure_q && (word_cmd || sig_cmd)) |-> refuse_o);
endmodule

// File: rtl/cfg_store_top.sv
module cfg_store_top
  import cfg_store_pkg::*;
#(
  parameter int NUM_WORDS = 64,
  parameter int DATA_W    = 32,
  parameter int SIG_W     = 64,
  parameter int ADDR_W    = 7,
  parameter int LATENCY   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ARR_DEPTH = NUM_WORDS + 1;
  localparam int SIG_WORDS = SIG_W / DATA_W;
  localparam int SIG_AW    = (SIG_WORDS > 1) ? $clog2(SIG_WORDS) : 1;

  logic              accept, fire;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              erase, wr, rd, sig_wr, sig_rd, refuse;
  logic [DATA_W-1:0] arr_rdata, sig_rdata;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  cfg_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i, .rst_ni, .req_i(cmd_valid_i), .accept_o(accept),
    .fire_o(fire), .busy_o, .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cmd_q   <= cmd_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  cfg_lock #(.NUM_WORDS(NUM_WORDS), .SIG_WORDS(SIG_WORDS), .ADDR_W(ADDR_W)) u_lock (
    .clk_i, .rst_ni, .fire_i(fire), .cmd_i(cmd_q), .addr_i(addr_q),
    .erase_o(erase), .wr_o(wr), .rd_o(rd), .sig_wr_o(sig_wr),
    .sig_rd_o(sig_rd), .refuse_o(refuse)
  );

  cfg_mem #(.DATA_W(DATA_W), .DEPTH(ARR_DEPTH), .AW(ADDR_W)) u_arr (
    .clk_i, .rst_ni, .erase_i(erase), .wr_i(wr), .addr_i(addr_q),
    .wdata_i(wdata_q), .rdata_o(arr_rdata)
  );

  cfg_mem #(.DATA_W(DATA_W), .DEPTH(SIG_WORDS), .AW(SIG_AW)) u_sig (
    .clk_i, .rst_ni, .erase_i(erase), .wr_i(sig_wr), .addr_i(addr_q[SIG_AW-1:0]),
    .wdata_i(wdata_q), .rdata_o(sig_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      err_q   <= refuse;
      rdata_q <= rd ? arr_rdata : (sig_rd ? sig_rdata : '0);
    end
  end

  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  assert_err_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_err_no_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  assert_rdata_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (rdata_o == '0));
endmodule

// File: tb/cfg_store_top_tb_top.sv
module cfg_store_top_tb_top;
  localparam int NW = 64, DW = 32, AW = 7, LAT = 4, SW = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [2:0]    cmd = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, done, err;
  logic [DW-1:0] rdata;

  int tests = 0, fails = 0;
  logic [DW-1:0] m_arr [NW+1];
  logic [DW-1:0] m_sig [SW];
  logic          m_sec;

  always #2.5 clk = ~clk;

  cfg_store_top #(.NUM_WORDS(NW), .DATA_W(DW), .SIG_W(64), .ADDR_W(AW), .LATENCY(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_i(cmd), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata)
  );

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] c, input logic [AW-1:0] a,
                                input logic [DW-1:0] d, output logic e, output logic [DW-1:0] r);
    e = 1'b0; r = '0;
    case (c)
      3'd1: begin
        for (int i = 0; i <= NW; i++) m_arr[i] = '0;
        for (int i = 0; i < SW; i++) m_sig[i] = '0;
        m_sec = 1'b0;
      end
      3'd2: if (m_sec || a > AW'(NW)) e = 1'b1; else m_arr[a] = m_arr[a] | d;
      3'd3: if (m_sec || a > AW'(NW)) e = 1'b1; else r = m_arr[a];
      3'd4: if (m_sec || a >= AW'(SW)) e = 1'b1; else m_sig[a[0]] = m_sig[a[0]] | d;
      3'd5: if (m_sec || a >= AW'(SW)) e = 1'b1; else r = m_sig[a[0]];
      3'd6: m_sec = 1'b1;
      default: ;
    endcase
  endfunction

  task automatic issue(string req, logic [2:0] c, logic [AW-1:0] a, logic [DW-1:0] d, bit inject);
    logic e; logic [DW-1:0] r;
    model(c, a, d, e, r);
    cmd = c; addr = a; wdata = d; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk("R2", "busy after accept", {31'b0, busy}, 1);
    chk("R5", "rdata idle", rdata, '0);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k == 1 && inject) begin
        cmd = 3'd2; addr = 6; wdata = '1; valid = 1'b1;
      end
      if (k == 2) valid = 1'b0;
      if (k == LAT - 1) chk("R2", "done early", {31'b0, done}, 0);
    end
    chk("R2", "done pulse", {31'b0, done}, 1);
    chk("R2", "busy low at done", {31'b0, busy}, 0);
    chk(req, "err", {31'b0, err}, {31'b0, e});
    chk(req, "rdata", rdata, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5e_0d17));
    for (int i = 0; i <= NW; i++) m_arr[i] = '0;
    for (int i = 0; i < SW; i++) m_sig[i] = '0;
    m_sec = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'b0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", {31'b0, busy}, 0);
    chk("R1", "done", {31'b0, done}, 0);
    chk("R1", "err", {31'b0, err}, 0);
    chk("R1", "rdata", rdata, '0);
    issue("R1", 3'd3, 5, '0, 0);
    issue("R1", 3'd5, 1, '0, 0);
    issue("R4", 3'd2, 5, 32'hA5A5_0000, 0);
    issue("R4", 3'd2, 5, 32'h0F0F_00FF, 0);
    issue("R4", 3'd3, 5, '0, 0);
    issue("R5", 3'd2, 7'(NW), 32'h0003_1234, 0);
    issue("R5", 3'd3, 7'(NW), '0, 0);
    issue("R10", 3'd3, 7'(NW + 1), '0, 0);
    issue("R10", 3'd2, 7'd127, '1, 0);
    issue("R7", 3'd4, 0, 32'hDEAD_BEEF, 0);
    issue("R7", 3'd4, 1, 32'h0123_4567, 0);
    issue("R7", 3'd5, 0, '0, 0);
    issue("R7", 3'd5, 1, '0, 0);
    issue("R10", 3'd5, 2, '0, 0);
    issue("R11", 3'd7, 5, '1, 0);
    issue("R11", 3'd0, 5, '1, 0);
    issue("R11", 3'd3, 5, '0, 0);
    issue("R3", 3'd3, 5, '0, 1);
    issue("R3", 3'd3, 6, '0, 0);
    issue("R8", 3'd6, 0, '0, 0);
    issue("R9", 3'd3, 5, '0, 0);
    issue("R9", 3'd2, 5, '1, 0);
    issue("R9", 3'd5, 0, '0, 0);
    issue("R9", 3'd4, 1, '1, 0);
    issue("R8", 3'd6, 0, '0, 0);
    issue("R6", 3'd1, 0, '0, 0);
    issue("R6", 3'd3, 5, '0, 0);
    issue("R6", 3'd3, 7'(NW), '0, 0);
    issue("R6", 3'd5, 0, '0, 0);
    issue("R6", 3'd5, 1, '0, 0);
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 99);
      logic [2:0] c;
      logic [AW-1:0] a;
      if (sel < 3) c = 3'd1;
      else if (sel < 6) c = 3'd6;
      else if (sel < 30) c = 3'd2;
      else if (sel < 55) c = 3'd3;
      else if (sel < 70) c = 3'd4;
      else if (sel < 85) c = 3'd5;
      else c = 3'($urandom_range(0, 7));
      a = (c == 3'd4 || c == 3'd5) ? AW'($urandom_range(0, 3)) : AW'($urandom_range(0, 127));
      issue("R9", c, a, $urandom, ($urandom_range(0, 9) == 0) && (c != 3'd1) && !m_sec ? 1'b0 : 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule